// File: doc/BRIEF.md
# Bridge Window Transaction Decoder

This block makes the forwarding decision for one bridge that joins a primary bus (the side nearer the processor) to a secondary bus (the side farther away). It holds three programmable address windows: an I/O window, a memory window for locations with read side effects (restricted to the low 4 GB), and a prefetchable memory window that covers the full 64-bit space. It also holds the primary, secondary and subordinate bus numbers. Subordinate is the highest bus number that lies below the bridge.

Each transaction is presented with a valid strobe, its kind (I/O or memory), its address and the side it arrives on. Traffic arriving on the primary side is claimed and sent downstream when it hits an enabled window. Traffic arriving on the secondary side is claimed and sent upstream when it misses every window of its kind, so device DMA reaches system memory. An optional subtractive mode also claims primary-side traffic that no window hits, provided no other agent on the bus has claimed it while the block was waiting.

The decision appears exactly two cycles after the strobe. A simple register-write port loads the windows, the bus numbers and the mode.

Top module: `bwin_decoder`

## Requirements
- R1: While reset is applied and after it is released, every window is disabled, subtractive mode is off and all three bus numbers read zero. As a result, a primary-side transaction is not claimed and a secondary-side transaction is claimed upstream.
- R2: A primary-side I/O transaction (`txn_is_mem`=0) is claimed downstream when all of these hold: the I/O limit is greater than the I/O base; address bits [63:32] are zero; and address bits [31:12] lie between the base and the limit, both inclusive.
- R3: A primary-side memory transaction (`txn_is_mem`=1) is claimed downstream through the non-prefetchable window when all of these hold: the memory limit is greater than the memory base; address bits [63:32] are zero; and address bits [31:20] lie between the base and the limit, both inclusive. No address at or above 4 GB hits this window.
- R4: The prefetchable window compares address bits [63:20] against a 44-bit base and a 44-bit limit, independently of the non-prefetchable window. A memory transaction is claimed downstream when either memory window hits it.
- R5: A window whose limit is not greater than its base hits no address.
- R6: A transaction on the secondary side (`txn_from_sec`=1) is claimed with `claim_down`=0 exactly when its address is outside every enabled window of its kind. A secondary-side transaction is never claimed subtractively.
- R7: With subtractive mode off, a primary-side transaction that hits no window is not claimed.
- R8: With subtractive mode on, a primary-side transaction that hits no window is claimed downstream with `claim_subtr`=1 when `peer_claim` is low both in the strobe cycle and in the cycle after it. When either sample is high, the transaction is not claimed. A window hit is always reported with `claim_subtr`=0.
- R9: `dec_valid` rises two clock cycles after each `txn_valid` cycle, and back-to-back transactions are accepted every cycle. While `dec_valid` is low, `claim`, `claim_down` and `claim_subtr` are low. `claim_down` is 1 only for a claimed primary-side transaction.
- R10: Writes with select 8, 9 and 10 load data bits [7:0] into the primary, secondary and subordinate bus numbers respectively. Each value is visible on its output from the cycle after the write.
- R11: Configuration write selects are as follows. I/O base 0 and I/O limit 1 take data [19:0]. Memory base 2 and memory limit 3 take data [11:0]. Prefetchable base takes its low part at select 4 (data [11:0] = address bits [31:20]) and its high part at select 5 (data [31:0] = address bits [63:32]). Prefetchable limit uses select 6 (low) and select 7 (high) in the same way. Select 11 bit 0 is the subtractive-mode enable. A decode uses the register values held before any write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| txn_valid | input | 1 | Transaction strobe |
| txn_is_mem | input | 1 | 1 = memory, 0 = I/O |
| txn_from_sec | input | 1 | 1 = arrives on the secondary side |
| txn_addr | input | 64 | Transaction byte address |
| peer_claim | input | 1 | Another agent on the primary bus has claimed |
| dec_valid | output | 1 | Decision strobe |
| claim | output | 1 | Bridge forwards the transaction |
| claim_down | output | 1 | Forwarding is downstream |
| claim_subtr | output | 1 | Claim was made subtractively |
| pri_bus | output | 8 | Primary bus number |
| sec_bus | output | 8 | Secondary bus number |
| sub_bus | output | 8 | Subordinate bus number |

## Verification
The properties assume that `peer_claim` only carries meaning in the strobe cycle and the cycle after it. They also assume that a configuration write that lands in the same cycle as a strobe affects only later strobes. The stimulus never changes the windows while a transaction it checks is inside the pipeline, and it drives `peer_claim` only around isolated primary-side transactions. Addresses are kept away from the top block of the 64-bit space, so a window end plus one never wraps.

// File: rtl/bwin_pkg.sv
`timescale 1ns/1ps
package bwin_pkg;

  typedef enum logic [3:0] {
    CSEL_IO_BASE   = 4'd0,
    CSEL_IO_LIM    = 4'd1,
    CSEL_MEM_BASE  = 4'd2,
    CSEL_MEM_LIM   = 4'd3,
    CSEL_PF_BASE_L = 4'd4,
    CSEL_PF_BASE_H = 4'd5,
    CSEL_PF_LIM_L  = 4'd6,
    CSEL_PF_LIM_H  = 4'd7,
    CSEL_BUS_PRI   = 4'd8,
    CSEL_BUS_SEC   = 4'd9,
    CSEL_BUS_SUB   = 4'd10,
    CSEL_MODE      = 4'd11
  } csel_e;

  typedef struct packed {
    logic claim;
    logic down;
    logic subtr;
  } verdict_t;

  // Final forwarding verdict from the stage-one facts.
  function automatic verdict_t judge(input logic from_sec, input logic pos_hit,
                                     input logic subtr_on, input logic peer_seen);
    verdict_t r;
    r = '0;
    if (from_sec) begin
      r.claim = !pos_hit;
    end else if (pos_hit) begin
      r.claim = 1'b1;
      r.down  = 1'b1;
    end else if (subtr_on && !peer_seen) begin
      r.claim = 1'b1;
      r.down  = 1'b1;
      r.subtr = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/bwin_window.sv
`timescale 1ns/1ps
module bwin_window #(
  parameter int W = 12
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] key,
  input  logic         key_ok,
  output logic         hit
);

  function automatic logic is_open(input logic [W-1:0] b, input logic [W-1:0] l);
    return l > b;
  endfunction

  function automatic logic covers(input logic [W-1:0] b, input logic [W-1:0] l,
                                  input logic [W-1:0] k);
    return (k >= b) && (k <= l);
  endfunction

  logic open;
  assign open = is_open(base, lim);
  assign hit  = open && key_ok && covers(base, lim, key);

endmodule

// File: rtl/bwin_cfg_regs.sv
`timescale 1ns/1ps
module bwin_cfg_regs
  import bwin_pkg::*;
#(
  parameter int CFG_W = 32,
  parameter int IOB_W = 20,
  parameter int MB_W  = 12,
  parameter int PFH_W = 32,
  parameter int BUS_W = 8,
  localparam int PB_W = PFH_W + MB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [3:0]       sel,
  input  logic [CFG_W-1:0] wdata,
  output logic [IOB_W-1:0] io_base,
  output logic [IOB_W-1:0] io_lim,
  output logic [MB_W-1:0]  mem_base,
  output logic [MB_W-1:0]  mem_lim,
  output logic [PB_W-1:0]  pf_base,
  output logic [PB_W-1:0]  pf_lim,
  output logic [BUS_W-1:0] pri_bus,
  output logic [BUS_W-1:0] sec_bus,
  output logic [BUS_W-1:0] sub_bus,
  output logic             subtr_en
);

  logic [MB_W-1:0]  pf_base_l, pf_lim_l;
  logic [PFH_W-1:0] pf_base_h, pf_lim_h;
  logic             wdata_unused;

  assign wdata_unused = ^wdata;
  assign pf_base = {pf_base_h, pf_base_l};
  assign pf_lim  = {pf_lim_h, pf_lim_l};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_base   <= '0;
      io_lim    <= '0;
      mem_base  <= '0;
      mem_lim   <= '0;
      pf_base_l <= '0;
      pf_base_h <= '0;
      pf_lim_l  <= '0;
      pf_lim_h  <= '0;
      pri_bus   <= '0;
      sec_bus   <= '0;
      sub_bus   <= '0;
      subtr_en  <= 1'b0;
    end else if (we) begin
      case (csel_e'(sel))
        CSEL_IO_BASE:   io_base   <= wdata[IOB_W-1:0];
        CSEL_IO_LIM:    io_lim    <= wdata[IOB_W-1:0];
        CSEL_MEM_BASE:  mem_base  <= wdata[MB_W-1:0];
        CSEL_MEM_LIM:   mem_lim   <= wdata[MB_W-1:0];
        CSEL_PF_BASE_L: pf_base_l <= wdata[MB_W-1:0];
        CSEL_PF_BASE_H: pf_base_h <= wdata[PFH_W-1:0];
        CSEL_PF_LIM_L:  pf_lim_l  <= wdata[MB_W-1:0];
        CSEL_PF_LIM_H:  pf_lim_h  <= wdata[PFH_W-1:0];
        CSEL_BUS_PRI:   pri_bus   <= wdata[BUS_W-1:0];
        CSEL_BUS_SEC:   sec_bus   <= wdata[BUS_W-1:0];
        CSEL_BUS_SUB:   sub_bus   <= wdata[BUS_W-1:0];
        CSEL_MODE:      subtr_en  <= wdata[0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/bwin_decide.sv
`timescale 1ns/1ps
module bwin_decide
  import bwin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_from_sec,
  input  logic in_is_mem,
  input  logic io_hit,
  input  logic mem_hit,
  input  logic pf_hit,
  input  logic subtr_en,
  input  logic peer_claim,
  output logic s1_valid,
  output logic s1_from_sec,
  output logic s1_pos,
  output logic s1_subtr_en,
  output logic dec_valid,
  output logic claim,
  output logic claim_down,
  output logic claim_subtr
);

  logic     pos_now;
  logic     s1_peer;
  verdict_t verdict;

  assign pos_now = in_is_mem ? (mem_hit | pf_hit) : io_hit;

  // Stage one: window result and first peer sample.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid    <= 1'b0;
      s1_from_sec <= 1'b0;
      s1_pos      <= 1'b0;
      s1_subtr_en <= 1'b0;
      s1_peer     <= 1'b0;
    end else begin
      s1_valid    <= in_valid;
      s1_from_sec <= in_valid & in_from_sec;
      s1_pos      <= in_valid & pos_now;
      s1_subtr_en <= subtr_en;
      s1_peer     <= peer_claim;
    end
  end

  assign verdict = judge(s1_from_sec, s1_pos, s1_subtr_en, s1_peer | peer_claim);

  // Stage two: second peer sample folded in, verdict registered.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      claim       <= 1'b0;
      claim_down  <= 1'b0;
      claim_subtr <= 1'b0;
    end else begin
      dec_valid   <= s1_valid;
      claim       <= s1_valid & verdict.claim;
      claim_down  <= s1_valid & verdict.down;
      claim_subtr <= s1_valid & verdict.subtr;
    end
  end

endmodule

// File: rtl/bwin_decoder.sv
`timescale 1ns/1ps
module bwin_decoder #(
  parameter int ADDR_W   = 64,
  parameter int IO_GRAN  = 12,
  parameter int MEM_GRAN = 20,
  parameter int BUS_W    = 8,
  parameter int CFG_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              txn_valid,
  input  logic              txn_is_mem,
  input  logic              txn_from_sec,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic              peer_claim,
  output logic              dec_valid,
  output logic              claim,
  output logic              claim_down,
  output logic              claim_subtr,
  output logic [BUS_W-1:0]  pri_bus,
  output logic [BUS_W-1:0]  sec_bus,
  output logic [BUS_W-1:0]  sub_bus
);

  localparam int IOB_W = 32 - IO_GRAN;
  localparam int MB_W  = 32 - MEM_GRAN;
  localparam int PFH_W = ADDR_W - 32;
  localparam int PB_W  = ADDR_W - MEM_GRAN;

  logic [IOB_W-1:0] io_base, io_lim;
  logic [MB_W-1:0]  mem_base, mem_lim;
  logic [PB_W-1:0]  pf_base, pf_lim;
  logic             subtr_en;
  logic             low_4g;
  logic             io_hit, mem_hit, pf_hit;
  logic             s1_valid, s1_from_sec, s1_pos, s1_subtr_en;
  logic             addr_unused;

  assign addr_unused = ^txn_addr[IO_GRAN-1:0];
  assign low_4g      = (txn_addr[ADDR_W-1:32] == '0);

  bwin_cfg_regs #(
    .CFG_W(CFG_W), .IOB_W(IOB_W), .MB_W(MB_W), .PFH_W(PFH_W), .BUS_W(BUS_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .io_base(io_base), .io_lim(io_lim), .mem_base(mem_base), .mem_lim(mem_lim),
    .pf_base(pf_base), .pf_lim(pf_lim), .pri_bus(pri_bus), .sec_bus(sec_bus),
    .sub_bus(sub_bus), .subtr_en(subtr_en)
  );

  bwin_window #(.W(IOB_W)) u_io_win (
    .base(io_base), .lim(io_lim), .key(txn_addr[31:IO_GRAN]),
    .key_ok(low_4g), .hit(io_hit)
  );

  bwin_window #(.W(MB_W)) u_mem_win (
    .base(mem_base), .lim(mem_lim), .key(txn_addr[31:MEM_GRAN]),
    .key_ok(low_4g), .hit(mem_hit)
  );

  bwin_window #(.W(PB_W)) u_pf_win (
    .base(pf_base), .lim(pf_lim), .key(txn_addr[ADDR_W-1:MEM_GRAN]),
    .key_ok(1'b1), .hit(pf_hit)
  );

  bwin_decide u_decide (
    .clk(clk), .rst_n(rst_n), .in_valid(txn_valid), .in_from_sec(txn_from_sec),
    .in_is_mem(txn_is_mem), .io_hit(io_hit), .mem_hit(mem_hit), .pf_hit(pf_hit),
    .subtr_en(subtr_en), .peer_claim(peer_claim),
    .s1_valid(s1_valid), .s1_from_sec(s1_from_sec), .s1_pos(s1_pos),
    .s1_subtr_en(s1_subtr_en), .dec_valid(dec_valid), .claim(claim),
    .claim_down(claim_down), .claim_subtr(claim_subtr)
  );

endmodule

// File: rtl/bwin_decoder_chk.sv
`timescale 1ns/1ps
module bwin_decoder_chk #(
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_valid,
  input logic             cfg_we,
  input logic [3:0]       cfg_sel,
  input logic [BUS_W-1:0] cfg_wbus,
  input logic             dec_valid,
  input logic             claim,
  input logic             claim_down,
  input logic             claim_subtr,
  input logic [BUS_W-1:0] sub_bus,
  input logic             s1_valid,
  input logic             s1_from_sec,
  input logic             s1_pos,
  input logic             s1_subtr_en
);

  AST_DEC_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> ##1 dec_valid); // R9

  AST_NO_STAGE_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !dec_valid); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!claim && !claim_down && !claim_subtr)); // R9

  AST_POS_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_from_sec && s1_pos) |=> (claim && claim_down && !claim_subtr)); // R2

  AST_UP_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_from_sec) |=> (claim == !$past(s1_pos))); // R6

  AST_UP_NOT_SUBTR: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_from_sec) |=> (!claim_down && !claim_subtr)); // R6

  AST_NO_SUBTR_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && !s1_subtr_en) |=> !claim_subtr); // R8

  AST_SUB_BUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 4'd10) |=> (sub_bus == $past(cfg_wbus))); // R10

endmodule

bind bwin_decoder bwin_decoder_chk #(.BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .cfg_we(cfg_we),
  .cfg_sel(cfg_sel), .cfg_wbus(cfg_wdata[BUS_W-1:0]), .dec_valid(dec_valid),
  .claim(claim), .claim_down(claim_down), .claim_subtr(claim_subtr),
  .sub_bus(sub_bus), .s1_valid(s1_valid), .s1_from_sec(s1_from_sec),
  .s1_pos(s1_pos), .s1_subtr_en(s1_subtr_en)
);

// File: tb/bwin_decoder_bench.sv
`timescale 1ns/1ps
module bwin_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        txn_valid = 1'b0;
  logic        txn_is_mem = 1'b0;
  logic        txn_from_sec = 1'b0;
  logic [63:0] txn_addr = '0;
  logic        peer_claim = 1'b0;
  logic        dec_valid, claim, claim_down, claim_subtr;
  logic [7:0]  pri_bus, sec_bus, sub_bus;

  bwin_decoder u_bwin_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .txn_valid(txn_valid), .txn_is_mem(txn_is_mem),
    .txn_from_sec(txn_from_sec), .txn_addr(txn_addr), .peer_claim(peer_claim),
    .dec_valid(dec_valid), .claim(claim), .claim_down(claim_down),
    .claim_subtr(claim_subtr), .pri_bus(pri_bus), .sec_bus(sec_bus),
    .sub_bus(sub_bus)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model state: windows kept as block numbers, compared as byte ranges.
  longint unsigned m_io_b, m_io_l, m_mem_b, m_mem_l, m_pf_b, m_pf_l;
  int  m_pri, m_sec, m_sub;
  bit  m_sub_on;
  bit  p1_v, p1_sec, p1_pos, p1_son, p1_peer;
  string p1_tag = "R9";
  bit  e_v, e_claim, e_down, e_subtr;
  string e_tag = "R9";
  string cur_tag = "R9";

  function automatic bit inside_range(longint unsigned a, longint unsigned b,
                                      longint unsigned l, int sh);
    longint unsigned lo, hi;
    if (l <= b) return 0;
    lo = b << sh;
    hi = ((l + 1) << sh) - 1;
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic bit model_hit(bit is_mem, longint unsigned a);
    bit below = (a < 64'h1_0000_0000);
    if (!is_mem) return below && inside_range(a, m_io_b, m_io_l, 12);
    return (below && inside_range(a, m_mem_b, m_mem_l, 20)) ||
           inside_range(a, m_pf_b, m_pf_l, 20);
  endfunction

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_io_b = 0; m_io_l = 0; m_mem_b = 0; m_mem_l = 0; m_pf_b = 0; m_pf_l = 0;
      m_pri = 0; m_sec = 0; m_sub = 0; m_sub_on = 0;
      p1_v = 0; e_v = 0; e_claim = 0; e_down = 0; e_subtr = 0;
    end else begin
      e_v = p1_v; e_claim = 0; e_down = 0; e_subtr = 0; e_tag = p1_tag;
      if (p1_v) begin
        if (p1_sec) e_claim = !p1_pos;
        else if (p1_pos) begin e_claim = 1; e_down = 1; end
        else if (p1_son && !p1_peer && !peer_claim) begin
          e_claim = 1; e_down = 1; e_subtr = 1;
        end
      end
      p1_v = txn_valid; p1_sec = txn_from_sec; p1_son = m_sub_on;
      p1_peer = peer_claim;
      p1_pos = txn_valid && model_hit(txn_is_mem, txn_addr);
      p1_tag = txn_valid ? cur_tag : "R9";
      if (cfg_we) begin
        case (cfg_sel)
          4'd0: m_io_b = cfg_wdata & 32'hF_FFFF;
          4'd1: m_io_l = cfg_wdata & 32'hF_FFFF;
          4'd2: m_mem_b = cfg_wdata & 32'hFFF;
          4'd3: m_mem_l = cfg_wdata & 32'hFFF;
          4'd4: m_pf_b = (m_pf_b & ~64'hFFF) | (cfg_wdata & 32'hFFF);
          4'd5: m_pf_b = (m_pf_b & 64'hFFF) | (longint'(cfg_wdata) << 12);
          4'd6: m_pf_l = (m_pf_l & ~64'hFFF) | (cfg_wdata & 32'hFFF);
          4'd7: m_pf_l = (m_pf_l & 64'hFFF) | (longint'(cfg_wdata) << 12);
          4'd8: m_pri = cfg_wdata & 8'hFF;
          4'd9: m_sec = cfg_wdata & 8'hFF;
          4'd10: m_sub = cfg_wdata & 8'hFF;
          4'd11: m_sub_on = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(e_tag, {dec_valid, claim, claim_down, claim_subtr},
          {e_v, e_claim, e_down, e_subtr});
      chk("R10", {pri_bus, sec_bus, sub_bus},
          {m_pri[7:0], m_sec[7:0], m_sub[7:0]});
    end
  end

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL R9 watchdog act=%0d exp=<20000", cycles);
      finish_run();
    end
  end

  task automatic wr(int sel, longint unsigned data);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel[3:0]; cfg_wdata = data[31:0];
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(bit mem, bit sec, longint unsigned a, bit pk0, bit pk1, string tag);
    @(negedge clk);
    cur_tag = tag; txn_valid = 1; txn_is_mem = mem; txn_from_sec = sec;
    txn_addr = a; peer_claim = pk0;
    @(negedge clk);
    txn_valid = 0; peer_claim = pk1;
    @(negedge clk);
    peer_claim = 0;
    @(negedge clk);
  endtask

  task automatic push(bit mem, bit sec, longint unsigned a, string tag);
    @(negedge clk);
    cur_tag = tag; txn_valid = 1; txn_is_mem = mem; txn_from_sec = sec; txn_addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", {dec_valid, claim, claim_down, claim_subtr}, 0);
    chk("R1", {pri_bus, sec_bus, sub_bus}, 0);
    rst_n = 1;

    // R1: reset windows closed
    send(1, 0, 64'hC000_0000, 0, 0, "R1 R7");
    send(1, 1, 64'hC000_0000, 0, 0, "R1 R6");
    send(0, 1, 64'h0000_2000, 0, 0, "R1 R6");
    send(0, 0, 64'h0000_0000, 0, 0, "R1 R5");

    // R2: I/O window 0x1000..0x3FFF
    wr(0, 1); wr(1, 3);
    send(0, 0, 64'h0000_1000, 0, 0, "R2 R11");
    send(0, 0, 64'h0000_3FFF, 0, 0, "R2");
    send(0, 0, 64'h0000_4000, 0, 0, "R2 R7");
    send(0, 0, 64'h0000_0FFF, 0, 0, "R2 R7");
    send(0, 0, 64'h1_0000_2000, 0, 0, "R2");
    send(1, 0, 64'h0000_2000, 0, 0, "R2");
    send(0, 1, 64'h0000_2000, 0, 0, "R6");
    send(0, 1, 64'h0000_5000, 0, 0, "R6");

    // R3: memory window 0xC000_0000..0xC0FF_FFFF
    wr(2, 12'hC00); wr(3, 12'hC0F);
    send(1, 0, 64'hC000_0000, 0, 0, "R3 R11");
    send(1, 0, 64'hC0FF_FFFF, 0, 0, "R3");
    send(1, 0, 64'hC100_0000, 0, 0, "R3 R7");
    send(1, 0, 64'hBFFF_FFFF, 0, 0, "R3 R7");
    send(1, 0, 64'h1_C000_0000, 0, 0, "R3");
    send(1, 1, 64'hC000_0010, 0, 0, "R6");

    // R4: prefetchable window 0x1_0000_0000..0x1_00FF_FFFF
    wr(5, 1); wr(4, 0); wr(7, 1); wr(6, 12'h00F);
    send(1, 0, 64'h1_0000_0000, 0, 0, "R4 R11");
    send(1, 0, 64'h1_00FF_FFFF, 0, 0, "R4");
    send(1, 0, 64'h1_0100_0000, 0, 0, "R4 R7");
    send(1, 0, 64'h0_FFFF_FFFF, 0, 0, "R4 R7");
    send(1, 1, 64'h1_0000_0040, 0, 0, "R4 R6");
    send(1, 1, 64'h8000_0000, 0, 0, "R6");

    // R5: closed windows
    wr(3, 12'hC00); wr(1, 0);
    send(1, 0, 64'hC000_0000, 0, 0, "R5");
    send(1, 1, 64'hC000_0000, 0, 0, "R5 R6");
    send(0, 0, 64'h0000_1000, 0, 0, "R5");

    // R8: subtractive mode
    wr(11, 1);
    send(1, 0, 64'h9000_0000, 0, 0, "R8 R11");
    send(1, 0, 64'h9000_0000, 1, 0, "R8");
    send(1, 0, 64'h9000_0000, 0, 1, "R8");
    send(1, 0, 64'h1_0000_0000, 1, 1, "R8 R4");
    send(1, 1, 64'h9000_0000, 0, 0, "R8 R6");
    send(0, 0, 64'h0000_7000, 0, 0, "R8");

    // R9: back-to-back stream
    push(1, 0, 64'h1_0000_0100, "R9");
    push(1, 1, 64'h1_0000_0100, "R9");
    push(1, 0, 64'h5000_0000, "R9");
    push(0, 1, 64'h0000_7000, "R9");
    push(1, 1, 64'hC000_0000, "R9");
    push(0, 0, 64'h0000_3000, "R9");
    @(negedge clk);
    txn_valid = 0;
    wr(11, 0);
    push(1, 0, 64'h5000_0000, "R7 R9");
    @(negedge clk);
    txn_valid = 0;
    repeat (3) @(negedge clk);

    // R10: bus numbers
    wr(8, 8'h02); wr(9, 8'h05); wr(10, 8'h09);
    chk("R10", {pri_bus, sec_bus, sub_bus}, 24'h02_05_09);
    wr(10, 8'hFE);
    chk("R10", sub_bus, 8'hFE);
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule